// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a processor reach the registers of Ethernet PHYs over the two-wire management bus (MDC clock, bidirectional MDIO data). Software uses five 32-bit word registers. It sets a PHY address and register number, then starts a transfer. A read starts when the read bit of the command word goes from 0 to 1. A write starts as soon as the 16-bit write data is stored. The controller then shifts out a complete Clause 22 management frame. On a read it releases MDIO for the turnaround and data bits and shifts in the PHY's reply.

MDC is derived from the system clock. Its half period is the parameter `DIV_HALF`, counted in system clocks. The frame shifter is one state machine with the states IDLE, PREAMBLE, HEADER, TURNAROUND, DATA and TAIL, and each state lasts a fixed number of MDC bit times:

- IDLE → PREAMBLE on an accepted start.
- PREAMBLE → HEADER after 32 bits.
- HEADER → TURNAROUND after 14 bits.
- TURNAROUND → DATA after 2 bits.
- DATA → TAIL after 16 bits.
- TAIL → IDLE at the next falling MDC edge. At that edge the read result is committed.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Word offsets on `bus_addr` are as follows:
  - 0: target, with the PHY address in bits 12:8 and the register number in bits 4:0.
  - 1: command, with the read bit at bit 0.
  - 2: write data, in bits 15:0.
  - 3: read result, in bits 15:0.
  - 4: flags, with busy at bit 0 and not-valid at bit 1.

  Reset clears every register to zero and leaves MDIO released (`mdio_oe_o` = 0).
- R2: MDC has a period of 2*DIV_HALF system clocks. The driven MDIO value changes only at falling MDC edges.
- R3: Every frame is sent MSB first in this order: 32 ones, start 01, opcode, 5-bit PHY address, 5-bit register number, two turnaround bits, then 16 data bits. The opcode is 10 for a read and 01 for a write.
- R4: A read frame starts only when a bus write changes command bit 0 from 0 to 1. Writing 1 while the bit is already 1 starts no frame.
- R5: A bus write to offset 2 starts a write frame carrying bits 15:0. The controller drives the turnaround bits as 10.
- R6: During the turnaround and data bits of a read, `mdio_oe_o` is low. The data is sampled at rising MDC edges and becomes the read result.
- R7: Busy reads 1 from the cycle after the triggering bus write until the 65th falling MDC edge of the frame.
- R8: Not-valid is set by a read start. It clears on the same clock edge that loads the read result.
- R9: A read from an absent PHY, where MDIO is left pulled high, returns 0xFFFF.
- R10: While busy, the following are ignored: bus writes to offsets 0 and 2, and a 0-to-1 command edge.
- R11: The read result holds its value until the next read completes. Write frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_we | input | 1 | Register write strobe, one cycle |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Resolved MDIO line level |

## Verification
The start of a transfer is accepted at the clock edge that takes the bus write. Busy and not-valid therefore read as set at the very next sample point, and the bench checks them there.

The end of a frame falls 64*2*DIV_HALF+1 to 65*2*DIV_HALF cycles after that edge, depending on the MDC phase. The bench counts the busy cycles and checks that the count lies in this window. The read result and the cleared not-valid flag appear on the same edge that drops busy, so the bench compares them at the first sample where busy reads 0.

Frame bits are taken from the line at every rising MDC edge. A bench PHY model answers on falling edges, so the result check depends on the rising-edge sampling.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA,
        ST_TAIL
    } mdio_state_e;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

    localparam logic [2:0] OFF_TARGET = 3'd0;
    localparam logic [2:0] OFF_CMD    = 3'd1;
    localparam logic [2:0] OFF_WDATA  = 3'd2;
    localparam logic [2:0] OFF_RESULT = 3'd3;
    localparam logic [2:0] OFF_FLAGS  = 3'd4;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc_o,
    output logic rise_tick_o,
    output logic fall_tick_o
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] div_q;
    logic          wrap;

    assign wrap        = (div_q == LAST);
    assign rise_tick_o = wrap && !mdc_o;
    assign fall_tick_o = wrap && mdc_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            mdc_o <= 1'b0;
        end else if (wrap) begin
            div_q <= '0;
            mdc_o <= ~mdc_o;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_MDC_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick_o |=> mdc_o);   // R2
    AST_MDC_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick_o |=> !mdc_o);  // R2
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_tick_i,
    input  logic        fall_tick_i,
    input  logic        start_i,
    input  logic        op_rd_i,
    input  logic [4:0]  phy_i,
    input  logic [4:0]  reg_i,
    input  logic [15:0] wdata_i,
    input  logic        mdio_i,
    output logic        busy_o,
    output logic        rd_done_o,
    output logic [15:0] rdata_o,
    output logic        mdio_o,
    output logic        mdio_oe_o
);
    mdio_state_e state_q, state_d;
    logic [4:0]  cnt_q;
    logic [13:0] hdr_q;
    logic [15:0] tx_q;
    logic [15:0] rx_q;
    logic        rd_q;
    logic        smp_q;
    logic        step;

    function automatic logic [4:0] last_idx(input mdio_state_e s);
        case (s)
            ST_PRE:  last_idx = 5'(PRE_BITS - 1);
            ST_HDR:  last_idx = 5'(HDR_BITS - 1);
            ST_TA:   last_idx = 5'(TA_BITS - 1);
            ST_DATA: last_idx = 5'(DATA_BITS - 1);
            default: last_idx = 5'd0;
        endcase
    endfunction

    assign step      = fall_tick_i && (cnt_q == last_idx(state_q));
    assign busy_o    = (state_q != ST_IDLE);
    assign rd_done_o = (state_q == ST_TAIL) && fall_tick_i && rd_q;
    assign rdata_o   = rx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)     state_d = ST_PRE;
            ST_PRE:  if (step)        state_d = ST_HDR;
            ST_HDR:  if (step)        state_d = ST_TA;
            ST_TA:   if (step)        state_d = ST_DATA;
            ST_DATA: if (step)        state_d = ST_TAIL;
            ST_TAIL: if (fall_tick_i) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            hdr_q     <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            rd_q      <= 1'b0;
            smp_q     <= 1'b0;
            mdio_o    <= 1'b1;
            mdio_oe_o <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (start_i) begin
                    cnt_q <= '0;
                    hdr_q <= {SOF_CODE, (op_rd_i ? OP_READ : OP_WRITE), phy_i, reg_i};
                    tx_q  <= wdata_i;
                    rd_q  <= op_rd_i;
                end
            end else if (fall_tick_i) begin
                cnt_q <= step ? 5'd0 : cnt_q + 5'd1;
                unique case (state_q)
                    ST_PRE: begin
                        mdio_o    <= 1'b1;
                        mdio_oe_o <= 1'b1;
                    end
                    ST_HDR: begin
                        mdio_o    <= hdr_q[13];
                        hdr_q     <= {hdr_q[12:0], 1'b0};
                        mdio_oe_o <= 1'b1;
                    end
                    ST_TA: begin
                        mdio_oe_o <= !rd_q;
                        mdio_o    <= rd_q ? 1'b1 : (cnt_q == 5'd0);
                    end
                    ST_DATA: begin
                        if (rd_q) begin
                            mdio_oe_o <= 1'b0;
                            mdio_o    <= 1'b1;
                            smp_q     <= 1'b1;
                        end else begin
                            mdio_o    <= tx_q[15];
                            tx_q      <= {tx_q[14:0], 1'b0};
                            mdio_oe_o <= 1'b1;
                        end
                    end
                    ST_TAIL: begin
                        mdio_oe_o <= 1'b0;
                        mdio_o    <= 1'b1;
                        smp_q     <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (rise_tick_i && smp_q) rx_q <= {rx_q[14:0], mdio_i};
        end
    end

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick_i |=> $stable(mdio_o));                          // R2
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mdio_oe_o);                       // R1
    AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (state_q == ST_IDLE));                          // R10
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && state_q == ST_DATA) |-> !mdio_oe_o);               // R6
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    logic [4:0]  phy_q;
    logic [4:0]  reg_q;
    logic        cmd_q;
    logic [15:0] wdat_q;
    logic [15:0] result_q;
    logic        nv_q;
    logic        busy;
    logic        rd_done;
    logic [15:0] eng_rdata;
    logic        rise_tick;
    logic        fall_tick;
    logic        hit_cmd;
    logic        hit_wdata;
    logic        start_rd;
    logic        start_wr;
    logic        unused_hi;

    assign unused_hi = ^bus_wdata[31:16];
    assign hit_cmd   = bus_we && (bus_addr == ADDR_W'(OFF_CMD));
    assign hit_wdata = bus_we && (bus_addr == ADDR_W'(OFF_WDATA));
    assign start_rd  = hit_cmd && bus_wdata[0] && !cmd_q && !busy;
    assign start_wr  = hit_wdata && !busy;

    mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) clkgen_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdc_o      (mdc_o),
        .rise_tick_o(rise_tick),
        .fall_tick_o(fall_tick)
    );

    mdio_frame_engine engine_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_tick_i(rise_tick),
        .fall_tick_i(fall_tick),
        .start_i    (start_rd || start_wr),
        .op_rd_i    (start_rd),
        .phy_i      (phy_q),
        .reg_i      (reg_q),
        .wdata_i    (bus_wdata[15:0]),
        .mdio_i     (mdio_i),
        .busy_o     (busy),
        .rd_done_o  (rd_done),
        .rdata_o    (eng_rdata),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q    <= '0;
            reg_q    <= '0;
            cmd_q    <= 1'b0;
            wdat_q   <= '0;
            result_q <= '0;
            nv_q     <= 1'b0;
        end else begin
            if (bus_we && bus_addr == ADDR_W'(OFF_TARGET) && !busy) begin
                phy_q <= bus_wdata[12:8];
                reg_q <= bus_wdata[4:0];
            end
            if (hit_cmd)  cmd_q  <= bus_wdata[0];
            if (start_wr) wdat_q <= bus_wdata[15:0];
            if (start_rd)     nv_q <= 1'b1;
            else if (rd_done) nv_q <= 1'b0;
            if (rd_done) result_q <= eng_rdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_TARGET): bus_rdata = {19'd0, phy_q, 3'd0, reg_q};
            ADDR_W'(OFF_CMD):    bus_rdata = {31'd0, cmd_q};
            ADDR_W'(OFF_WDATA):  bus_rdata = {16'd0, wdat_q};
            ADDR_W'(OFF_RESULT): bus_rdata = {16'd0, result_q};
            ADDR_W'(OFF_FLAGS):  bus_rdata = {30'd0, nv_q, busy};
            default:             bus_rdata = {31'd0, unused_hi & 1'b0};
        endcase
    end

    AST_NV_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        nv_q |-> busy);                              // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> $stable(result_q));             // R11
    AST_BUSY_TILL_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall_tick) |=> busy);              // R7
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
    localparam int DIV_HALF = 2;
    localparam int P = 2 * DIV_HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc_o, mdio_o, mdio_oe_o, mdio_line;

    logic        phy_present = 1'b1;
    logic        phy_drv = 1'b0;
    logic        phy_bit = 1'b1;
    logic [15:0] phy_val = '0;
    logic [63:0] sr = '0;
    int          nbits = 0;
    int          kneg = 0;
    bit          rd_phase = 1'b0;
    bit          oe_bad = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #4 clk = ~clk;

    assign mdio_line = mdio_oe_o ? mdio_o : ((phy_drv && phy_present) ? phy_bit : 1'b1);

    mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF), .ADDR_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_line)
    );

    function automatic logic [15:0] phy_model(input logic [4:0] pa, input logic [4:0] ra);
        return (16'(pa) * 16'h0123 + 16'(ra) * 16'h1011) ^ 16'h5A3C;
    endfunction

    // PHY model: record driven bits at rising MDC, answer reads at falling MDC
    always @(posedge mdc_o) begin
        if (rd_phase && mdio_oe_o) oe_bad = 1'b1;
        if (mdio_oe_o) begin
            sr = {sr[62:0], mdio_o};
            nbits++;
            if (nbits == 46 && sr[11:10] == 2'b10) begin
                rd_phase = 1'b1;
                kneg = 0;
                phy_val = phy_model(sr[9:5], sr[4:0]);
            end
        end
    end

    always @(negedge mdc_o) begin
        if (rd_phase) begin
            kneg++;
            if (kneg == 1) phy_drv = 1'b0;
            else if (kneg == 2) begin phy_drv = 1'b1; phy_bit = 1'b0; end
            else if (kneg <= 18) phy_bit = phy_val[15 - (kneg - 3)];
            else begin phy_drv = 1'b0; rd_phase = 1'b0; end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // returns the number of sample points with busy set
    task automatic wait_idle(output int n);
        logic [31:0] f;
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            bus_read(3'd4, f);
            if (!f[0]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        logic [31:0] f;
        int n;
        bus_write(3'd0, {19'd0, pa, 3'd0, ra});
        nbits = 0;
        bus_write(3'd2, {16'hDEAD, d});
        bus_read(3'd4, f);
        chk(f[1:0] == 2'b01, "R7 busy after write start", 64'(f[1:0]), 64'd1);
        wait_idle(n);
        chk(n >= 64*P+1 && n <= 65*P, "R7 write busy length", 64'(n), 64'(65*P));
        chk(nbits == 64, "R3 write bit count", 64'(nbits), 64'd64);
        chk(sr[63:32] == 32'hFFFFFFFF && sr[31:30] == 2'b01, "R3 preamble and start",
            sr[63:30], {32'hFFFFFFFF, 2'b01});
        chk(sr[29:28] == 2'b01 && sr[27:23] == pa && sr[22:18] == ra, "R5 write header",
            64'(sr[29:18]), 64'({2'b01, pa, ra}));
        chk(sr[17:16] == 2'b10 && sr[15:0] == d, "R5 write turnaround and data",
            64'(sr[17:0]), 64'({2'b10, d}));
    endtask

    task automatic do_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] exp);
        logic [31:0] f;
        int n;
        bus_write(3'd0, {19'd0, pa, 3'd0, ra});
        bus_write(3'd1, 32'd0);
        nbits = 0;
        oe_bad = 1'b0;
        bus_write(3'd1, 32'd1);
        bus_read(3'd4, f);
        chk(f[1:0] == 2'b11, "R8 busy and not-valid after read start", 64'(f[1:0]), 64'd3);
        wait_idle(n);
        chk(n >= 64*P+1 && n <= 65*P, "R7 read busy length", 64'(n), 64'(65*P));
        chk(nbits == 46 && sr[45:14] == 32'hFFFFFFFF, "R3 read preamble", 64'(nbits), 64'd46);
        chk(sr[13:10] == 4'b0110 && sr[9:5] == pa && sr[4:0] == ra, "R4 read header",
            64'(sr[13:0]), 64'({4'b0110, pa, ra}));
        chk(!oe_bad, "R6 line released in turnaround and data", 64'(oe_bad), 64'd0);
        bus_read(3'd3, f);
        chk(f == {16'd0, exp}, "R6 R9 read result", 64'(f), 64'(exp));
        bus_read(3'd4, f);
        chk(f[1] == 1'b0, "R8 not-valid cleared with result", 64'(f[1]), 64'd0);
    endtask

    initial begin
        logic [31:0] f;
        logic [31:0] keep;
        int n;
        time t1, t2;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(3'd4, f); chk(f == 0, "R1 flags at reset", 64'(f), 0);
        bus_read(3'd3, f); chk(f == 0, "R1 result at reset", 64'(f), 0);
        bus_read(3'd0, f); chk(f == 0, "R1 target at reset", 64'(f), 0);
        chk(mdio_oe_o == 1'b0, "R1 line released at reset", 64'(mdio_oe_o), 0);

        // R2 MDC period
        @(posedge mdc_o); t1 = $time;
        @(posedge mdc_o); t2 = $time;
        chk((t2 - t1) == P * 8, "R2 MDC period", 64'(t2 - t1), 64'(P * 8));

        // directed: write then read back through a PHY model
        do_write(5'd3, 5'd9, 16'hA55A);
        do_read(5'd3, 5'd9, phy_model(5'd3, 5'd9));
        do_read(5'd31, 5'd31, phy_model(5'd31, 5'd31));

        // R11 result survives a write frame
        bus_read(3'd3, keep);
        do_write(5'd0, 5'd0, 16'h0000);
        bus_read(3'd3, f);
        chk(f == keep, "R11 result held across write", 64'(f), 64'(keep));

        // R4 level of the command bit does not start a frame
        nbits = 0;
        bus_write(3'd1, 32'd1);
        bus_read(3'd4, f);
        chk(f[1:0] == 2'b00, "R4 no read on held bit", 64'(f[1:0]), 0);
        repeat (40) @(negedge clk);
        chk(nbits == 0, "R4 no frame bits on held bit", 64'(nbits), 0);

        // R9 absent PHY
        phy_present = 1'b0;
        do_read(5'd7, 5'd2, 16'hFFFF);
        phy_present = 1'b1;

        // R10 writes and command edge during busy
        bus_write(3'd1, 32'd0);
        bus_write(3'd0, {19'd0, 5'd4, 3'd0, 5'd1});
        nbits = 0;
        bus_write(3'd2, 32'h0000_1234);
        bus_write(3'd0, {19'd0, 5'd30, 3'd0, 5'd30});
        bus_write(3'd2, 32'h0000_BEEF);
        bus_write(3'd1, 32'd1);
        bus_read(3'd0, f);
        chk(f == {19'd0, 5'd4, 3'd0, 5'd1}, "R10 target ignored while busy", 64'(f), 64'h0401);
        bus_read(3'd2, f);
        chk(f == 32'h1234, "R10 write data ignored while busy", 64'(f), 64'h1234);
        bus_read(3'd4, f);
        chk(f[1] == 1'b0, "R10 command edge ignored while busy", 64'(f[1]), 0);
        wait_idle(n);
        chk(nbits == 64 && sr[15:0] == 16'h1234, "R10 single frame with first data",
            64'(sr[15:0]), 64'h1234);
        repeat (4 * P) @(negedge clk);
        bus_read(3'd4, f);
        chk(f[0] == 1'b0, "R10 no queued frame", 64'(f[0]), 0);

        // constrained random mix
        for (int i = 0; i < 14; i++) begin
            logic [31:0] r;
            logic [4:0]  pa, ra;
            r  = $urandom;
            pa = 5'($urandom % 32);
            ra = 5'($urandom % 32);
            if (r[0]) do_read(pa, ra, phy_model(pa, ra));
            else      do_write(pa, ra, 16'($urandom));
        end

        summary();
        $finish;
    end
endmodule